// File: doc/BRIEF.md
# Glitch-Safe Divided Pixel Clock Generator

This block produces one divided clock, of the kind a display controller uses as its pixel clock. It can pick from three source clocks. A single 32-bit control word holds the source code, the divide value and three handshake bits. A change to the source or the divider is applied only while the output is low. The output therefore never shows a shortened high or low phase.

Software first sets the change-enable bit. For a source change it also sets the stop bit. It then writes the new field values and polls the busy bit until it reads zero. Finally it clears the handshake bits.

All logic runs on one fast control clock, `clk`. Each source clock is brought into that domain through a synchronizer. Both of its edges are detected there. The output is a flop driven by these edge events, so it is free of glitches by construction. Each source's half-period must be at least three `clk` cycles.

Top module: `pixclk_changer`

## Requirements
- R1: After reset, `rd_data` reads zero and `clk_out` is low. Zero means source code 0, divide value 0, and all handshake bits clear.
- R2: The control word has this layout:
  - bits 31:30: source code
  - bit 29: change-enable
  - bit 28: busy (read-only)
  - bit 27: stop
  - bits 7:0: divide value
  
  Every other bit reads zero. Writing bit 28 has no effect.
- R3: A write updates the source and divide fields only when two conditions hold: change-enable was already set before the write, and the written word also has bit 29 set. Any other write leaves both fields and the output period unchanged. Every write loads the change-enable bit and the stop bit.
- R4: Busy reads 1 from the cycle after an accepted field write. It stays 1 while `clk_out` is high. It clears one cycle after `clk_out` is low, and at that point the new setting is active.
- R5: With divide value D (0 to 255), the output period is D+1 periods of the selected source clock. The high time is exactly half the period.
- R6: Source codes 0, 1 and 2 select `src_clk[0]`, `src_clk[1]` and `src_clk[2]`. Code 3 means no clock, and `clk_out` stays low.
- R7: When stop is set, the output first completes any high phase in progress and is then held low. While the output is stopped and low, an accepted change takes effect on the next cycle.
- R8: After stop is cleared, the first high pulse has the full width of D+1 source half-periods.
- R9: Suppose a field write lands on the cycle in which a pending change would be applied. The write wins: busy stays set, and the newest values are the ones applied.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Control and sampling clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| src_clk | input | 3 | Source clocks, one per source code 0..2 |
| wr_en | input | 1 | Write strobe for the control word |
| wr_data | input | 32 | Control word to write |
| rd_data | output | 32 | Current control word |
| clk_out | output | 1 | Divided, glitch-free output clock |

## Verification
Two actions can fall in the same cycle: applying a pending change and accepting a new field write. The bench provokes this while the output is stopped and low. It writes one divide value, then writes a second value on the very next cycle, which is the cycle in which the first would be applied. It expects busy to stay high across both writes and to clear one cycle later. It then expects the output period measured after restart to match the second value only.

// File: rtl/pixclk_changer.sv
module pixclk_changer #(
  parameter int NSRC        = 3,
  parameter int SEL_W       = 2,
  parameter int DIV_W       = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NSRC-1:0] src_clk,
  input  logic            wr_en,
  input  logic [31:0]     wr_data,
  output logic [31:0]     rd_data,
  output logic            clk_out
);

  localparam int SEL_LSB  = 32 - SEL_W;
  localparam int CE_BIT   = SEL_LSB - 1;
  localparam int BUSY_BIT = SEL_LSB - 2;
  localparam int STOP_BIT = SEL_LSB - 3;
  localparam int NCODES   = 2 ** SEL_W;

  logic [SEL_W-1:0] pend_sel, act_sel;
  logic [DIV_W-1:0] pend_div, act_div, cnt;
  logic             ce_q, busy_q, stop_q;
  logic [NSRC-1:0]  src_ev;
  logic [NCODES-1:0] ev_pad;

  genvar i;
  generate
    for (i = 0; i < NSRC; i++) begin : g_sync
      logic [SYNC_STAGES:0] sh;
      always_ff @(posedge clk or negedge rst_n)
        if (!rst_n) sh <= '0;
        else        sh <= {sh[SYNC_STAGES-1:0], src_clk[i]};
      assign src_ev[i] = sh[SYNC_STAGES] ^ sh[SYNC_STAGES-1];
    end
  endgenerate

  assign ev_pad = {{(NCODES-NSRC){1'b0}}, src_ev};

  logic ev_sel, run, wr_accept, apply_now;
  assign ev_sel    = ev_pad[act_sel];
  assign run       = !stop_q && (int'(act_sel) < NSRC);
  assign wr_accept = wr_en && ce_q && wr_data[CE_BIT];
  assign apply_now = busy_q && !clk_out && !wr_accept;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ce_q     <= 1'b0;
      stop_q   <= 1'b0;
      busy_q   <= 1'b0;
      pend_sel <= '0;
      pend_div <= '0;
      act_sel  <= '0;
      act_div  <= '0;
    end else begin
      if (wr_en) begin
        ce_q   <= wr_data[CE_BIT];
        stop_q <= wr_data[STOP_BIT];
      end
      if (wr_accept) begin
        pend_sel <= wr_data[SEL_LSB +: SEL_W];
        pend_div <= wr_data[DIV_W-1:0];
        busy_q   <= 1'b1;
      end else if (apply_now) begin
        act_sel <= pend_sel;
        act_div <= pend_div;
        busy_q  <= 1'b0;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt     <= '0;
      clk_out <= 1'b0;
    end else if (apply_now || (!run && !clk_out)) begin
      cnt <= '0;
    end else if (ev_sel) begin
      if (cnt == act_div) begin
        cnt     <= '0;
        clk_out <= ~clk_out;
      end else begin
        cnt <= cnt + 1'b1;
      end
    end
  end

  always_comb begin
    rd_data                      = '0;
    rd_data[SEL_LSB +: SEL_W]    = pend_sel;
    rd_data[CE_BIT]              = ce_q;
    rd_data[BUSY_BIT]            = busy_q;
    rd_data[STOP_BIT]            = stop_q;
    rd_data[DIV_W-1:0]           = pend_div;
  end

  assert_ignored_write_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !ce_q) |=> ($stable(pend_div) && $stable(pend_sel)));

  assert_busy_clears_low_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy_q) |-> !clk_out);

  assert_settled_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !busy_q |-> (act_div == pend_div && act_sel == pend_sel));

  assert_change_while_low_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (!$stable(act_div) || !$stable(act_sel)) |-> !clk_out);

  assert_no_clock_code_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (int'(act_sel) >= NSRC && !clk_out) |=> !clk_out);

  assert_stop_holds_low_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (stop_q && !clk_out) |=> !clk_out);

endmodule

// File: tb/pixclk_changer_bench.sv
module pixclk_changer_bench;
  localparam int CLK_PERIOD = 10;
  localparam int NV = 7;
  localparam int V_SEL [NV] = '{0, 0, 1, 2, 2, 1, 0};
  localparam int V_DIV [NV] = '{0, 2, 1, 0, 3, 4, 255};
  localparam int V_PER [NV] = '{8, 24, 24, 20, 80, 60, 2048};
  localparam int LIM = 10000;

  logic clk = 0, rst_n = 0, wr_en = 0;
  logic [2:0] src_clk = '0;
  logic [31:0] wr_data = '0, rd_data;
  logic clk_out;
  int errors = 0, checks = 0;

  pixclk_changer u_pixclk_changer (.clk(clk), .rst_n(rst_n), .src_clk(src_clk),
    .wr_en(wr_en), .wr_data(wr_data), .rd_data(rd_data), .clk_out(clk_out));

  always #(CLK_PERIOD/2) clk = ~clk;
  initial begin #3; forever #40  src_clk[0] = ~src_clk[0]; end
  initial begin #7; forever #60  src_clk[1] = ~src_clk[1]; end
  initial begin #9; forever #100 src_clk[2] = ~src_clk[2]; end

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] word(input int sel, input bit ce, input bit stp, input int div);
    logic [31:0] w;
    w = '0; w[31:30] = sel[1:0]; w[29] = ce; w[27] = stp; w[7:0] = div[7:0];
    return w;
  endfunction

  task automatic wr(input logic [31:0] d);
    @(negedge clk); wr_en = 1; wr_data = d;
    @(negedge clk); wr_en = 0;
  endtask

  task automatic wait_busy_clear();
    int t = 0;
    while (rd_data[28] && t < LIM) begin @(negedge clk); t++; end
  endtask

  task automatic set_cfg(input int sel, input int div);
    wr(word(rd_data[31:30], 1, 1, rd_data[7:0]));
    wr(word(sel, 1, 1, div));
    wait_busy_clear();
    wr(word(sel, 0, 0, div));
  endtask

  task automatic measure(output int per, output int hi);
    int t = 0;
    per = 0; hi = 0;
    while (clk_out !== 1'b0 && t < LIM) begin @(negedge clk); t++; end
    while (clk_out !== 1'b1 && t < LIM) begin @(negedge clk); t++; end
    while (clk_out === 1'b1 && t < LIM) begin @(negedge clk); hi++; t++; end
    per = hi;
    while (clk_out === 1'b0 && t < LIM) begin @(negedge clk); per++; t++; end
  endtask

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog actual=timeout expected=done");
    summary();
  end

  initial begin
    int per, hi, bad;
    repeat (5) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk(rd_data == 32'h0, "R1 reset word", rd_data, 0);
    chk(clk_out == 1'b0, "R1 reset output", clk_out, 0);

    // R2/R3: busy bit, stray bit and fields written with change-enable clear
    wr(32'h5000_0155);
    chk(rd_data == 32'h0, "R2 R3 ignored write", rd_data, 0);
    measure(per, hi); measure(per, hi);
    chk(per == 8, "R3 period unchanged", per, 8);

    // R3: enable set in the same write does not accept fields
    wr(word(0, 1, 0, 8'h33));
    chk(rd_data == 32'h2000_0000, "R3 same-write enable", rd_data, 32'h2000_0000);
    wr(word(0, 0, 0, 0));

    // R5/R6 table walk
    for (int k = 0; k < NV; k++) begin
      set_cfg(V_SEL[k], V_DIV[k]);
      chk(rd_data == word(V_SEL[k], 0, 0, V_DIV[k]), "R2 field readback", rd_data, word(V_SEL[k], 0, 0, V_DIV[k]));
      measure(per, hi); measure(per, hi);
      chk(per == V_PER[k], "R5 R6 period", per, V_PER[k]);
      chk(hi == V_PER[k]/2, "R5 duty", hi, V_PER[k]/2);
    end

    // R4: divider change without stop while output high (div 255 in force)
    wr(word(0, 1, 0, 255));
    while (clk_out !== 1'b1) @(negedge clk);
    wr(word(0, 1, 0, 1));
    chk(rd_data[28] == 1'b1, "R4 busy after write", rd_data[28], 1);
    bad = 0;
    while (clk_out === 1'b1) begin
      if (!rd_data[28]) bad++;
      @(negedge clk);
    end
    chk(bad == 0, "R4 busy held during high", bad, 0);
    @(negedge clk);
    chk(rd_data[28] == 1'b0, "R4 busy cleared while low", rd_data[28], 0);
    wr(word(0, 0, 0, 1));
    measure(per, hi); measure(per, hi);
    chk(per == 16, "R4 new divider active", per, 16);

    // R7: stop holds output low, change applies at once
    wr(word(0, 1, 1, 1));
    repeat (40) @(negedge clk);
    bad = 0;
    repeat (200) begin if (clk_out) bad++; @(negedge clk); end
    chk(bad == 0, "R7 stop holds low", bad, 0);
    wr(word(0, 1, 1, 5));
    chk(rd_data[28] == 1'b1, "R7 busy set", rd_data[28], 1);
    @(negedge clk);
    chk(rd_data[28] == 1'b0, "R7 immediate apply", rd_data[28], 0);
    wr(word(0, 0, 0, 5));
    hi = 0;
    while (clk_out !== 1'b1) @(negedge clk);
    while (clk_out === 1'b1) begin @(negedge clk); hi++; end
    chk(hi == 24, "R8 first pulse full width", hi, 24);

    // R6: code 3 gives no clock
    set_cfg(3, 0);
    bad = 0;
    repeat (300) begin if (clk_out) bad++; @(negedge clk); end
    chk(bad == 0, "R6 code 3 low", bad, 0);
    set_cfg(2, 1);
    measure(per, hi); measure(per, hi);
    chk(per == 40, "R6 source 2 after code 3", per, 40);

    // R9: write on the apply cycle
    wr(word(2, 1, 1, 1));
    repeat (60) @(negedge clk);
    @(negedge clk); wr_en = 1; wr_data = word(0, 1, 1, 1);
    @(negedge clk); wr_data = word(0, 1, 1, 4);
    chk(rd_data[28] == 1'b1, "R9 busy after first", rd_data[28], 1);
    @(negedge clk); wr_en = 0;
    chk(rd_data[28] == 1'b1, "R9 busy held on collision", rd_data[28], 1);
    @(negedge clk);
    chk(rd_data[28] == 1'b0, "R9 busy clears after", rd_data[28], 0);
    chk(rd_data[7:0] == 8'd4, "R9 newest divider kept", rd_data[7:0], 4);
    wr(word(0, 0, 0, 4));
    measure(per, hi); measure(per, hi);
    chk(per == 40, "R9 newest divider applied", per, 40);

    summary();
  end
endmodule